// File: doc/BRIEF.md
# Windowed Address Decoder with Decode-Error Latching

This block sits beside a DMA master and turns each request address into a routing decision. Four programmable windows each hold an enable, a 4-bit target identifier, an 8-bit attribute, a 64 KB-aligned base and a power-of-two size kept as size-minus-one in 64 KB pages. Every valid request is compared against all windows in parallel. One clock later the block returns the winning window's index, target and attribute, or a decode-error response when nothing matched.

Two faults are recorded in a sticky error status register. One is a miss, where no enabled window covers the address. The other is a multiple hit, where two or more enabled windows cover the same address. When windows overlap, the lowest-numbered one still routes the request. Software clears status bits by writing ones. A mask register selects which status bits drive the interrupt line, and masking never stops an error from being latched.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rsp_valid and irq are 0, and every register reads 0.
- R2: Window n has its control register at byte offset 0x108 + 8n and its base register at 0x10C + 8n. Control bit 0 is the enable, bits 7:4 are the target, bits 15:8 are the attribute, and bits 31:16 are size-minus-one in 64 KB pages. Control bits 3:1 read 0. The base keeps only bits 31:16, and its bits 15:0 read 0.
- R3: A request taken with req_valid high produces rsp_valid high on the next clock edge. An enabled window n hits when (req_addr[31:16] & ~size_m1) equals (base[31:16] & ~size_m1). On a hit the response carries that window's target, attribute and index (rsp_win).
- R4: A window with enable 0 never hits, whatever its base and size.
- R5: When several enabled windows hit, the lowest-numbered one supplies rsp_win, rsp_target and rsp_attr. rsp_multi is 1 and rsp_miss is 0.
- R6: When no window hits, rsp_miss is 1, and rsp_target, rsp_attr and rsp_win are all 0.
- R7: The error status register at offset 0x12C has bit 0 for a miss and bit 1 for a multiple hit. The bit is set on the same clock edge that registers the response, and it stays set until it is cleared.
- R8: Writing to 0x12C clears each status bit written as 1. Bits written as 0 are left unchanged.
- R9: If a request sets a status bit on the same edge that a write clears it, the bit ends up set.
- R10: The mask register at offset 0x130 holds bits 1:0. irq is 1 whenever a status bit is 1 and its mask bit is 0. Masking does not prevent a status bit from being latched.
- R11: While req_valid is low, rsp_valid is 0 on the next edge and the status register changes only through writes to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_miss | output | 1 | Decode error: no window hit |
| rsp_multi | output | 1 | More than one window hit |
| rsp_win | output | WIN_IDX_W | Index of the selected window |
| rsp_target | output | 4 | Target ID of the selected window |
| rsp_attr | output | 8 | Attribute of the selected window |
| irq | output | 1 | Unmasked decode error pending |

## Verification
The error latch can be set by a decoded request and cleared by a software write in the same cycle. The bench provokes this by driving a status write and a request in the same half-period. It covers three cases: a miss while bit 0 is being cleared, a multiple hit while both bits are being cleared, and a clean hit while both bits are being cleared. After each case, reading the status must show exactly the bits the new request raised, with the set taking precedence over the clear. The random phase also mixes clearing writes with overlapping, partly disabled windows, and it checks every response and status read against a bench model.

// File: rtl/adec_pkg.sv
// Shared constants and types for the windowed address decoder.
// Assumes a 32-bit register data path and 64 KB window granularity.
package adec_pkg;
    localparam int unsigned WORD_W         = 32;
    localparam int unsigned PAGE_W         = 16;
    localparam int unsigned TGT_W          = 4;
    localparam int unsigned ATTR_W         = 8;
    localparam int unsigned ERR_W          = 2;
    localparam int unsigned ERR_MISS       = 0;
    localparam int unsigned ERR_MULTI      = 1;
    localparam int unsigned OFS_WIN0_CTRL  = 32'h108;
    localparam int unsigned OFS_WIN_STRIDE = 8;
    localparam int unsigned OFS_BASE_DELTA = 4;
    localparam int unsigned OFS_ERR_STAT   = 32'h12C;
    localparam int unsigned OFS_ERR_MASK   = 32'h130;

    typedef struct packed {
        logic [PAGE_W-1:0] size_m1;
        logic [ATTR_W-1:0] attr;
        logic [TGT_W-1:0]  target;
        logic              en;
    } win_cfg_t;
endpackage

// File: rtl/adec_regs.sv
// Register file of the decoder: per-window control and base, sticky
// error status with write-one-to-clear, and the error mask.
// Assumes a single write port and a combinational read on reg_addr.
// A status bit raised by err_set wins over a clear in the same cycle.
module adec_regs import adec_pkg::*; #(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned RADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic [ERR_W-1:0]   err_set,
    output win_cfg_t           win_cfg  [NUM_WIN],
    output logic [PAGE_W-1:0]  win_base [NUM_WIN],
    output logic [ERR_W-1:0]   err_status,
    output logic [ERR_W-1:0]   err_mask
);
    localparam logic [RADDR_W-1:0] STAT_ADDR = RADDR_W'(OFS_ERR_STAT);
    localparam logic [RADDR_W-1:0] MASK_ADDR = RADDR_W'(OFS_ERR_MASK);

    logic [ERR_W-1:0] clr_bits;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[3:1];

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        localparam int unsigned CTRL_OFS = OFS_WIN0_CTRL + OFS_WIN_STRIDE * gi;
        localparam int unsigned BASE_OFS = CTRL_OFS + OFS_BASE_DELTA;
        win_cfg_t          cfg_q;
        logic [PAGE_W-1:0] base_q;

        // Capture the used control fields of this window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else if (reg_we && reg_addr == RADDR_W'(CTRL_OFS)) begin
                cfg_q <= win_cfg_t'({reg_wdata[31:16], reg_wdata[15:8],
                                     reg_wdata[7:4], reg_wdata[0]});
            end
        end

        // Capture the 64 KB-aligned base page of this window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
            end else if (reg_we && reg_addr == RADDR_W'(BASE_OFS)) begin
                base_q <= reg_wdata[31:16];
            end
        end

        assign win_cfg[gi]  = cfg_q;
        assign win_base[gi] = base_q;
    end

    // Bits written as one to the status offset request a clear.
    always_comb begin
        clr_bits = '0;
        if (reg_we && reg_addr == STAT_ADDR) begin
            clr_bits = reg_wdata[ERR_W-1:0];
        end
    end

    // Sticky error status; a new error outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_status <= '0;
        end else begin
            err_status <= (err_status & ~clr_bits) | err_set;
        end
    end

    // Error mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_mask <= '0;
        end else if (reg_we && reg_addr == MASK_ADDR) begin
            err_mask <= reg_wdata[ERR_W-1:0];
        end
    end

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_addr == RADDR_W'(OFS_WIN0_CTRL + OFS_WIN_STRIDE * i)) begin
                reg_rdata = {win_cfg[i].size_m1, win_cfg[i].attr,
                             win_cfg[i].target, 3'b000, win_cfg[i].en};
            end
            if (reg_addr == RADDR_W'(OFS_WIN0_CTRL + OFS_WIN_STRIDE * i + OFS_BASE_DELTA)) begin
                reg_rdata = {win_base[i], {(WORD_W-PAGE_W){1'b0}}};
            end
        end
        if (reg_addr == STAT_ADDR) begin
            reg_rdata = {{(WORD_W-ERR_W){1'b0}}, err_status};
        end
        if (reg_addr == MASK_ADDR) begin
            reg_rdata = {{(WORD_W-ERR_W){1'b0}}, err_mask};
        end
    end
endmodule

// File: rtl/adec_match.sv
// Parallel window comparators: one masked page compare per window.
// Assumes size_m1 is a run of low-order ones (power-of-two size).
module adec_match import adec_pkg::*; #(
    parameter int unsigned NUM_WIN = 4
) (
    input  logic [PAGE_W-1:0]  page,
    input  logic [NUM_WIN-1:0] win_en,
    input  logic [PAGE_W-1:0]  win_size [NUM_WIN],
    input  logic [PAGE_W-1:0]  win_base [NUM_WIN],
    output logic [NUM_WIN-1:0] hit_vec
);
    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
        // Compare only the page bits above the window size.
        always_comb begin
            hit_vec[gi] = win_en[gi] &&
                ((page & ~win_size[gi]) == (win_base[gi] & ~win_size[gi]));
        end
    end
endmodule

// File: rtl/adec_select.sv
// Priority selection over the hit vector: lowest index wins, and the
// block flags no hit and more than one hit.
// Assumes NUM_WIN is at least 1.
module adec_select #(
    parameter int unsigned NUM_WIN   = 4,
    parameter int unsigned WIN_IDX_W = 2
) (
    input  logic [NUM_WIN-1:0]   hit_vec,
    output logic                 any_hit,
    output logic                 multi_hit,
    output logic [WIN_IDX_W-1:0] win_idx
);
    // Scan downward so the lowest set index is the last assignment.
    always_comb begin
        win_idx = '0;
        any_hit = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_idx = WIN_IDX_W'(i);
                any_hit = 1'b1;
            end
        end
    end

    // More than one bit set when clearing the lowest still leaves one.
    always_comb begin
        multi_hit = (hit_vec & (hit_vec - 1'b1)) != '0;
    end
endmodule

// File: rtl/addr_window_decoder.sv
// Windowed address decoder top: decodes each request against the
// programmed windows, registers the response one cycle later, latches
// miss and multiple-hit errors and drives an interrupt for unmasked errors.
// Assumes requests may arrive every cycle and need no back-pressure.
module addr_window_decoder import adec_pkg::*; #(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned RADDR_W = 12,
    localparam int unsigned WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [RADDR_W-1:0]   reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_miss,
    output logic                 rsp_multi,
    output logic [WIN_IDX_W-1:0] rsp_win,
    output logic [3:0]           rsp_target,
    output logic [7:0]           rsp_attr,
    output logic                 irq
);
    win_cfg_t               win_cfg  [NUM_WIN];
    logic [PAGE_W-1:0]      win_base [NUM_WIN];
    logic [PAGE_W-1:0]      win_size [NUM_WIN];
    logic [NUM_WIN-1:0]     win_en;
    logic [NUM_WIN-1:0]     hit_vec;
    logic                   any_hit;
    logic                   multi_hit;
    logic [WIN_IDX_W-1:0]   win_idx;
    logic [ERR_W-1:0]       err_set;
    logic [ERR_W-1:0]       err_status;
    logic [ERR_W-1:0]       err_mask;
    logic [TGT_W-1:0]       sel_target;
    logic [ATTR_W-1:0]      sel_attr;
    logic                   unused_offset;

    assign unused_offset = ^req_addr[PAGE_W-1:0];

    adec_regs #(.NUM_WIN(NUM_WIN), .RADDR_W(RADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_set(err_set),
        .win_cfg(win_cfg), .win_base(win_base),
        .err_status(err_status), .err_mask(err_mask)
    );

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_split
        assign win_en[gi]   = win_cfg[gi].en;
        assign win_size[gi] = win_cfg[gi].size_m1;
    end

    adec_match #(.NUM_WIN(NUM_WIN)) u_match (
        .page(req_addr[31:16]), .win_en(win_en), .win_size(win_size),
        .win_base(win_base), .hit_vec(hit_vec)
    );

    adec_select #(.NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W)) u_sel (
        .hit_vec(hit_vec), .any_hit(any_hit), .multi_hit(multi_hit),
        .win_idx(win_idx)
    );

    // Route the selected window's fields, or zero on a miss.
    always_comb begin
        sel_target = '0;
        sel_attr   = '0;
        if (any_hit) begin
            sel_target = win_cfg[win_idx].target;
            sel_attr   = win_cfg[win_idx].attr;
        end
    end

    // Errors raised by the request taken this cycle.
    always_comb begin
        err_set = '0;
        if (req_valid) begin
            err_set[ERR_MISS]  = !any_hit;
            err_set[ERR_MULTI] = multi_hit;
        end
    end

    // Response valid follows the request by exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
        end
    end

    // Response payload is captured only for a taken request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_miss   <= 1'b0;
            rsp_multi  <= 1'b0;
            rsp_win    <= '0;
            rsp_target <= '0;
            rsp_attr   <= '0;
        end else if (req_valid) begin
            rsp_miss   <= !any_hit;
            rsp_multi  <= multi_hit;
            rsp_win    <= win_idx;
            rsp_target <= sel_target;
            rsp_attr   <= sel_attr;
        end
    end

    // Interrupt from latched errors that are not masked.
    always_comb begin
        irq = |(err_status & ~err_mask);
    end
endmodule

// File: rtl/adec_checker.sv
// Protocol checker for the windowed address decoder, bound to the top.
module adec_checker #(
    parameter int unsigned RADDR_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [RADDR_W-1:0] reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               req_valid,
    input logic               rsp_valid,
    input logic               rsp_miss,
    input logic               rsp_multi,
    input logic [3:0]         rsp_target,
    input logic [7:0]         rsp_attr,
    input logic               irq,
    input logic [1:0]         err_status
);
    localparam logic [RADDR_W-1:0] STAT_ADDR = RADDR_W'(adec_pkg::OFS_ERR_STAT);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R3
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11
    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_target == 4'd0 && rsp_attr == 8'd0)); // R6
    AST_MISS_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> err_status[0]); // R7
    AST_MULTI_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_multi) |-> err_status[1]); // R9
    AST_MULTI_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_multi) |-> !rsp_miss); // R5
    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !(reg_we && reg_addr == STAT_ADDR)) |=> $stable(err_status)); // R11
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && reg_we && reg_addr == STAT_ADDR)
        |=> ((err_status & $past(reg_wdata[1:0])) == 2'b00)); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (err_status != 2'b00)); // R10
endmodule

bind addr_window_decoder adec_checker #(.RADDR_W(RADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_miss(rsp_miss), .rsp_multi(rsp_multi), .rsp_target(rsp_target),
    .rsp_attr(rsp_attr), .irq(irq), .err_status(err_status)
);

// File: tb/tb_addr_window_decoder.sv
// Self-checking bench: directed corners plus seeded random traffic.
module tb_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_miss, rsp_multi, irq;
    logic [1:0]  rsp_win;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [31:0] m_ctrl [4];
    logic [31:0] m_base [4];
    logic [1:0]  m_stat = 2'b00;
    logic [1:0]  m_mask = 2'b00;

    addr_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_multi(rsp_multi), .rsp_win(rsp_win), .rsp_target(rsp_target),
        .rsp_attr(rsp_attr), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit win_hit(input int i, input logic [31:0] a);
        logic [15:0] sz;
        sz = m_ctrl[i][31:16];
        return m_ctrl[i][0] && ((a[31:16] & ~sz) == (m_base[i][31:16] & ~sz));
    endfunction

    function automatic int hit_count(input logic [31:0] a);
        int n = 0;
        for (int i = 0; i < 4; i++) if (win_hit(i, a)) n++;
        return n;
    endfunction

    function automatic int first_hit(input logic [31:0] a);
        for (int i = 0; i < 4; i++) if (win_hit(i, a)) return i;
        return 0;
    endfunction

    function automatic logic [1:0] err_of(input logic [31:0] a);
        int n = hit_count(a);
        return {n > 1, n == 0};
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h12C) m_stat = m_stat & ~d[1:0];
        else if (a == 12'h130) m_mask = d[1:0];
        else if (a >= 12'h108 && a < 12'h128) begin
            if ((a - 12'h108) % 8 == 0) m_ctrl[(a - 12'h108) / 8] = d;
            else if ((a - 12'h108) % 8 == 4) m_base[(a - 12'h108) / 8] = d;
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic chk_rsp(input logic [31:0] a, input string tag);
        int n = hit_count(a);
        int f = first_hit(a);
        logic [31:0] exp, act;
        exp = {15'd0, 1'b1, n == 0, n > 1, (n > 0) ? f[1:0] : 2'd0,
               (n > 0) ? m_ctrl[f][7:4] : 4'd0, (n > 0) ? m_ctrl[f][15:8] : 8'd0};
        act = {15'd0, rsp_valid, rsp_miss, rsp_multi, rsp_win, rsp_target, rsp_attr};
        chk(act == exp, tag, act, exp);
    endtask

    task automatic req(input logic [31:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        m_stat = m_stat | err_of(a);
        chk_rsp(a, tag);
        chk(irq == |(m_stat & ~m_mask), "R10 irq", {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
    endtask

    // Status clear and request in the same cycle.
    task automatic collide(input logic [31:0] a, input logic [1:0] clr, input string tag);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h12C; reg_wdata = {30'd0, clr};
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        reg_we = 1'b0; req_valid = 1'b0;
        m_stat = (m_stat & ~clr) | err_of(a);
        chk_rsp(a, tag);
        rd_chk(12'h12C, {30'd0, m_stat}, tag);
    endtask

    task automatic program_random();
        for (int i = 0; i < 4; i++) begin
            logic [31:0] c;
            logic [15:0] sz;
            sz = 16'((32'd1 << ($urandom % 3)) - 1);
            c = {sz, 8'($urandom), 4'($urandom), 3'($urandom), ($urandom % 4) != 0};
            wr(12'(12'h108 + 8 * i), c);
            wr(12'(12'h10C + 8 * i), {16'($urandom % 16), 16'($urandom)});
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin m_ctrl[i] = '0; m_base[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(rsp_valid == 1'b0 && irq == 1'b0, "R1 reset outputs", {30'd0, rsp_valid, irq}, 32'd0);
        rd_chk(12'h108, 32'd0, "R1 ctrl0");
        rd_chk(12'h124, 32'd0, "R1 base3");
        rd_chk(12'h12C, 32'd0, "R1 status");
        rd_chk(12'h130, 32'd0, "R1 mask");

        // R4 all disabled: miss
        req(32'h0000_1234, "R4 disabled windows miss");
        rd_chk(12'h12C, 32'd1, "R7 miss latched");

        // R2 field layout and readback
        wr(12'h108, 32'h0003_A57F);
        rd_chk(12'h108, 32'h0003_A571, "R2 ctrl readback");
        wr(12'h10C, 32'h0004_BEEF);
        rd_chk(12'h10C, 32'h0004_0000, "R2 base readback");
        // R3 hit within 256 KB window
        req(32'h0006_FFFC, "R3 hit win0");
        req(32'h0008_0000, "R6 miss above window");

        // R4 disabled overlapping window ignored, R5 overlap priority
        wr(12'h110, 32'h0000_9900);
        wr(12'h114, 32'h0005_0000);
        req(32'h0005_0010, "R4 disabled win1 ignored");
        wr(12'h118, 32'h0000_3C21);
        wr(12'h11C, 32'h0005_0000);
        req(32'h0005_0010, "R5 multi hit lowest wins");
        rd_chk(12'h12C, 32'd3, "R7 both bits latched");

        // R8 write-one-to-clear
        wr(12'h12C, 32'd0);
        rd_chk(12'h12C, 32'd3, "R8 zero write no effect");
        wr(12'h12C, 32'd1);
        rd_chk(12'h12C, 32'd2, "R8 clear bit0 only");

        // R10 mask
        wr(12'h130, 32'd3);
        #1 chk(irq == 1'b0, "R10 masked irq", {31'd0, irq}, 32'd0);
        req(32'h00F0_0000, "R10 miss while masked");
        rd_chk(12'h12C, 32'd3, "R10 masking keeps latching");
        wr(12'h130, 32'd2);
        #1 chk(irq == 1'b1, "R10 unmasked bit0", {31'd0, irq}, 32'd1);
        wr(12'h130, 32'd0);

        // R9 set against clear in the same cycle
        collide(32'h00F0_0000, 2'b01, "R9 miss beats clear");
        collide(32'h0005_0000, 2'b11, "R9 multi beats clear");
        collide(32'h0006_0000, 2'b11, "R9 plain hit clears all");

        // R11 idle: no response, status untouched
        req(32'h00F0_0000, "R11 prime miss");
        @(negedge clk);
        req_addr = 32'h00F0_0000;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 idle no rsp", {31'd0, rsp_valid}, 32'd0);
        rd_chk(12'h12C, {30'd0, m_stat}, "R11 idle status held");

        // Random traffic against the model
        for (int it = 0; it < 400; it++) begin
            int sel;
            if (it % 50 == 0) program_random();
            sel = $urandom % 20;
            if (sel < 14) req({16'($urandom % 16), 16'($urandom)}, "R3 random decode");
            else if (sel < 17) wr(12'h12C, {30'd0, 2'($urandom)});
            else rd_chk(12'h12C, {30'd0, m_stat}, "R7 random status");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule